// File: doc/BRIEF.md
# Link-Change Interrupt Aggregator

This block collects link-state transitions from eight network ports and folds them into one shared active-low interrupt request. Each port keeps a sticky pending flag. The flag is set by any rising or falling edge on that port's synchronized link-up input. A management read of that port's interrupt-status register returns the flag and clears it.

The interrupt stays low until every flagged port has been read. A port that sees a new transition after it was read in a sweep is flagged again, so the line stays low once the sweep ends. The same management access path reaches a per-port configuration register. Two bits of that register are each ORed with a device-wide input pin and driven out as per-port bypass controls.

Management addresses are 5 bits wide. The upper 2 bits must equal the two strap inputs, and the lower 3 bits select the port. Four devices with different strap values therefore cover the whole address space, and an access to any other group is ignored. A two-state machine tracks the read response. In ST_IDLE there is no response. An accepted read moves the machine to ST_RESP, which lasts one cycle with read data valid. ST_RESP stays in ST_RESP if another read is accepted and otherwise returns to ST_IDLE. Writes take effect at the accepting edge and produce no response.

Top module: `link_irq_agg`

## Requirements
- R1: After reset, `irq_n` is 1, `rd_valid` is 0, every pending flag and configuration bit is 0, and both bypass output vectors equal the replicated pin values.
- R2: A rising or a falling edge on `link_up[p]` sets port p's pending flag. The flag drives `irq_n` low on the third clock edge after the input changes, and not earlier.
- R3: A read request with `mgmt_reg` = 5'h13 and `mgmt_phy` = {strap, p} is answered on the next cycle: `rd_valid` is 1 and `rd_data` bit 4 holds port p's flag, with all other bits 0. The flag clears on the same edge.
- R4: `irq_n` stays low while any flag is set. It goes high in the cycle after the last pending port is read.
- R5: A port that is read and then sees a new transition during the sweep is flagged again, and `irq_n` is still low after the other ports have been read.
- R6: When a transition and a read-clear hit the same port on the same edge, the flag stays set. The read returns 1 and a later read returns 1 again.
- R7: A request whose `mgmt_phy` upper 2 bits differ from `strap` produces no response (`rd_valid` stays 0), clears no flag and writes no register.
- R8: A write to `mgmt_reg` = 5'h11 stores `mgmt_wdata` bits 14 and 15 for the addressed port. A read of 5'h11 returns them in the same positions, with all other bits 0.
- R9: `blk_bypass[p]` is configuration bit 14 of port p ORed with `pin_blk_bypass`. `scr_bypass[p]` is configuration bit 15 of port p ORed with `pin_scr_bypass`.
- R10: Changing `strap` moves the port group to addresses strap*8 through strap*8+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap | input | 2 | Address group select |
| link_up | input | 8 | Asynchronous per-port link state |
| pin_blk_bypass | input | 1 | Device-wide block-code bypass pin |
| pin_scr_bypass | input | 1 | Device-wide scrambler bypass pin |
| mgmt_req | input | 1 | Management access strobe |
| mgmt_wr | input | 1 | 1 = write, 0 = read |
| mgmt_phy | input | 5 | Port address |
| mgmt_reg | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Read response data |
| irq_n | output | 1 | Active-low aggregate interrupt |
| blk_bypass | output | 8 | Per-port block-code bypass |
| scr_bypass | output | 8 | Per-port scrambler bypass |

## Verification
A link-input change passes through two synchronizer stages and one edge register, so the bench drives it at a falling edge and checks that `irq_n` is still high two cycles later and low after the third. Reads, writes and clears all act at the first rising edge after the strobe. The bench therefore samples `rd_valid`, `rd_data`, the bypass outputs and `irq_n` at the next falling edge. To test the case where set wins over clear, the bench issues the read exactly two cycles after the link toggle, so that both events land on the same edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NPORT       = 8;
    localparam int PORT_W      = $clog2(NPORT);
    localparam int ADDR_W      = 5;
    localparam int STRAP_W     = ADDR_W - PORT_W;
    localparam int DATA_W      = 16;
    localparam logic [ADDR_W-1:0] REG_CFG = 5'h11;
    localparam logic [ADDR_W-1:0] REG_ISR = 5'h13;
    localparam int ISR_LNK_BIT = 4;
    localparam int CFG_BLK_BIT = 14;
    localparam int CFG_SCR_BIT = 15;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } mg_state_t;
endpackage

// File: rtl/lnk_edge_det.sv
module lnk_edge_det #(
    parameter int NPORT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPORT-1:0] link_i,
    output logic [NPORT-1:0] chg_o
);
    logic [SYNC_STAGES-1:0][NPORT-1:0] sync_q;
    logic [NPORT-1:0]                  prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= '0;
        else         sync_q[0] <= link_i;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[s] <= '0;
            else         sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign chg_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
    parameter int NPORT = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPORT-1:0] set_i,
    input  logic [NPORT-1:0] clr_i,
    output logic [NPORT-1:0] pend_o
);
    logic [NPORT-1:0] pend_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       pend_q[p] <= 1'b0;
            else if (set_i[p]) pend_q[p] <= 1'b1;
            else if (clr_i[p]) pend_q[p] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))) else $error("set lost"); // R6
    AST_CLR_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q != '0) |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0)) else $error("flag dropped without read"); // R3
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
    parameter int NPORT  = 8,
    parameter int PORT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [PORT_W-1:0] wr_port_i,
    input  logic              wr_blk_i,
    input  logic              wr_scr_i,
    input  logic              pin_blk_i,
    input  logic              pin_scr_i,
    output logic [NPORT-1:0]  cfg_blk_o,
    output logic [NPORT-1:0]  cfg_scr_o,
    output logic [NPORT-1:0]  blk_o,
    output logic [NPORT-1:0]  scr_o
);
    logic [NPORT-1:0] blk_q;
    logic [NPORT-1:0] scr_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                blk_q[p] <= 1'b0;
                scr_q[p] <= 1'b0;
            end else if (wr_en_i && (wr_port_i == PORT_W'(p))) begin
                blk_q[p] <= wr_blk_i;
                scr_q[p] <= wr_scr_i;
            end
        end
        assign blk_o[p] = blk_q[p] | pin_blk_i;
        assign scr_o[p] = scr_q[p] | pin_scr_i;
    end

    assign cfg_blk_o = blk_q;
    assign cfg_scr_o = scr_q;

    AST_BLK_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_blk_i |-> (&blk_o)) else $error("blk pin not forced"); // R9
    AST_SCR_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_scr_i |-> (&scr_o)) else $error("scr pin not forced"); // R9
endmodule

// File: rtl/mgmt_ctrl.sv
module mgmt_ctrl
    import irq_agg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [NPORT-1:0]  pend_i,
    input  logic [NPORT-1:0]  cfg_blk_i,
    input  logic [NPORT-1:0]  cfg_scr_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NPORT-1:0]  clr_o,
    output logic              wr_en_o,
    output logic [PORT_W-1:0] wr_port_o,
    output logic              wr_blk_o,
    output logic              wr_scr_o
);
    mg_state_t         state_q, state_d;
    logic              hit;
    logic              acc_rd;
    logic [PORT_W-1:0] port;
    logic [DATA_W-1:0] rd_data_q;
    logic              unused_wbits;

    assign port   = phy_i[PORT_W-1:0];
    assign hit    = (phy_i[ADDR_W-1:PORT_W] == strap_i);
    assign acc_rd = req_i && !wr_i && hit;

    assign clr_o     = (acc_rd && reg_i == REG_ISR) ? (NPORT'(1) << port) : '0;
    assign wr_en_o   = req_i && wr_i && hit && (reg_i == REG_CFG);
    assign wr_port_o = port;
    assign wr_blk_o  = wdata_i[CFG_BLK_BIT];
    assign wr_scr_o  = wdata_i[CFG_SCR_BIT];
    assign unused_wbits = ^wdata_i[CFG_BLK_BIT-1:0];

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = acc_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = acc_rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // response data register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= '0;
            if (acc_rd) begin
                if (reg_i == REG_ISR) begin
                    rd_data_q[ISR_LNK_BIT] <= pend_i[port];
                end else if (reg_i == REG_CFG) begin
                    rd_data_q[CFG_BLK_BIT] <= cfg_blk_i[port];
                    rd_data_q[CFG_SCR_BIT] <= cfg_scr_i[port];
                end
            end
        end
    end

    assign rd_valid_o = (state_q == ST_RESP);
    assign rd_data_o  = rd_data_q;

    AST_RD_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_rd |=> rd_valid_o) else $error("read not answered"); // R3
    AST_NO_STRAY_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_rd |=> !rd_valid_o) else $error("response without accepted read"); // R7
endmodule

// File: rtl/link_irq_agg.sv
module link_irq_agg
    import irq_agg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  strap,
    input  logic [7:0]  link_up,
    input  logic        pin_blk_bypass,
    input  logic        pin_scr_bypass,
    input  logic        mgmt_req,
    input  logic        mgmt_wr,
    input  logic [4:0]  mgmt_phy,
    input  logic [4:0]  mgmt_reg,
    input  logic [15:0] mgmt_wdata,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        irq_n,
    output logic [7:0]  blk_bypass,
    output logic [7:0]  scr_bypass
);
    logic [NPORT-1:0]  chg;
    logic [NPORT-1:0]  clr;
    logic [NPORT-1:0]  pend;
    logic [NPORT-1:0]  cfg_blk;
    logic [NPORT-1:0]  cfg_scr;
    logic              wr_en;
    logic [PORT_W-1:0] wr_port;
    logic              wr_blk;
    logic              wr_scr;

    lnk_edge_det #(.NPORT(NPORT), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i (clk), .rst_ni (rst_n), .link_i (link_up), .chg_o (chg)
    );

    pend_bank #(.NPORT(NPORT)) u_pend (
        .clk_i (clk), .rst_ni (rst_n), .set_i (chg), .clr_i (clr), .pend_o (pend)
    );

    mgmt_ctrl u_mgmt (
        .clk_i (clk), .rst_ni (rst_n),
        .req_i (mgmt_req), .wr_i (mgmt_wr), .phy_i (mgmt_phy), .reg_i (mgmt_reg),
        .wdata_i (mgmt_wdata), .strap_i (strap), .pend_i (pend),
        .cfg_blk_i (cfg_blk), .cfg_scr_i (cfg_scr),
        .rd_valid_o (rd_valid), .rd_data_o (rd_data), .clr_o (clr),
        .wr_en_o (wr_en), .wr_port_o (wr_port), .wr_blk_o (wr_blk), .wr_scr_o (wr_scr)
    );

    cfg_bank #(.NPORT(NPORT), .PORT_W(PORT_W)) u_cfg (
        .clk_i (clk), .rst_ni (rst_n),
        .wr_en_i (wr_en), .wr_port_i (wr_port), .wr_blk_i (wr_blk), .wr_scr_i (wr_scr),
        .pin_blk_i (pin_blk_bypass), .pin_scr_i (pin_scr_bypass),
        .cfg_blk_o (cfg_blk), .cfg_scr_o (cfg_scr),
        .blk_o (blk_bypass), .scr_o (scr_bypass)
    );

    assign irq_n = ~(|pend);

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && clr == '0) |=> !irq_n) else $error("irq released without read"); // R4
endmodule

// File: tb/link_irq_agg_tb.sv
module link_irq_agg_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [4:0] R_ISR = 5'h13;
    localparam logic [4:0] R_CFG = 5'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap = 2'b00;
    logic [7:0]  link_up = '0;
    logic        pin_blk_bypass = 1'b0;
    logic        pin_scr_bypass = 1'b0;
    logic        mgmt_req = 1'b0;
    logic        mgmt_wr = 1'b0;
    logic [4:0]  mgmt_phy = '0;
    logic [4:0]  mgmt_reg = '0;
    logic [15:0] mgmt_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        irq_n;
    logic [7:0]  blk_bypass;
    logic [7:0]  scr_bypass;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_irq_agg u_dut (
        .clk (clk), .rst_n (rst_n), .strap (strap), .link_up (link_up),
        .pin_blk_bypass (pin_blk_bypass), .pin_scr_bypass (pin_scr_bypass),
        .mgmt_req (mgmt_req), .mgmt_wr (mgmt_wr), .mgmt_phy (mgmt_phy),
        .mgmt_reg (mgmt_reg), .mgmt_wdata (mgmt_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data), .irq_n (irq_n),
        .blk_bypass (blk_bypass), .scr_bypass (scr_bypass)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg,
                           output logic v, output logic [15:0] d);
        mgmt_req = 1'b1; mgmt_wr = 1'b0; mgmt_phy = phy; mgmt_reg = rg;
        @(negedge clk);
        v = rd_valid; d = rd_data;
        mgmt_req = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        mgmt_req = 1'b1; mgmt_wr = 1'b1; mgmt_phy = phy; mgmt_reg = rg; mgmt_wdata = wd;
        @(negedge clk);
        mgmt_req = 1'b0; mgmt_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 irq_n", 32'(irq_n), 1);
        check("R1 rd_valid", 32'(rd_valid), 0);
        check("R1 blk", 32'(blk_bypass), 0);
        check("R1 scr", 32'(scr_bypass), 0);
    endtask

    task automatic t_single;
        logic v; logic [15:0] d;
        link_up[1] = ~link_up[1];
        cyc(2);
        check("R2 irq_n not yet", 32'(irq_n), 1);
        cyc(1);
        check("R2 irq_n low on third edge", 32'(irq_n), 0);
        do_read(5'b00_001, R_ISR, v, d);
        check("R3 valid", 32'(v), 1);
        check("R3 data", 32'(d), 32'h0010);
        check("R4 irq_n released", 32'(irq_n), 1);
        cyc(1);
        check("R3 valid one cycle", 32'(rd_valid), 0);
        do_read(5'b00_001, R_ISR, v, d);
        check("R3 cleared", 32'(d), 0);
    endtask

    task automatic t_fall;
        logic v; logic [15:0] d;
        link_up[1] = 1'b0;
        cyc(3);
        check("R2 falling edge", 32'(irq_n), 0);
        do_read(5'b00_001, R_ISR, v, d);
        check("R2 falling flag", 32'(d), 32'h0010);
    endtask

    task automatic t_sweep;
        logic v; logic [15:0] d;
        link_up = link_up ^ 8'b0100_1001;
        cyc(3);
        do_read(5'b00_000, R_ISR, v, d);
        check("R4 p0 data", 32'(d), 32'h0010);
        check("R4 low after p0", 32'(irq_n), 0);
        do_read(5'b00_011, R_ISR, v, d);
        check("R4 low after p3", 32'(irq_n), 0);
        do_read(5'b00_110, R_ISR, v, d);
        check("R4 p6 data", 32'(d), 32'h0010);
        check("R4 high after last", 32'(irq_n), 1);
    endtask

    task automatic t_reflag;
        logic v; logic [15:0] d;
        link_up = link_up ^ 8'b0000_0110;
        cyc(3);
        do_read(5'b00_001, R_ISR, v, d);
        link_up[1] = ~link_up[1];
        cyc(3);
        do_read(5'b00_010, R_ISR, v, d);
        check("R5 irq still low after sweep", 32'(irq_n), 0);
        do_read(5'b00_001, R_ISR, v, d);
        check("R5 p1 reflagged", 32'(d), 32'h0010);
        check("R5 released", 32'(irq_n), 1);
    endtask

    task automatic t_set_wins;
        logic v; logic [15:0] d;
        link_up[5] = ~link_up[5];
        cyc(3);
        link_up[5] = ~link_up[5];
        cyc(2);
        do_read(5'b00_101, R_ISR, v, d);
        check("R6 read sees flag", 32'(d), 32'h0010);
        check("R6 irq held", 32'(irq_n), 0);
        do_read(5'b00_101, R_ISR, v, d);
        check("R6 flag survived", 32'(d), 32'h0010);
        do_read(5'b00_101, R_ISR, v, d);
        check("R6 then clear", 32'(d), 0);
        check("R6 irq released", 32'(irq_n), 1);
    endtask

    task automatic t_foreign;
        logic v; logic [15:0] d;
        link_up[3] = ~link_up[3];
        cyc(3);
        do_read(5'b01_011, R_ISR, v, d);
        check("R7 no response", 32'(v), 0);
        check("R7 no clear", 32'(irq_n), 0);
        do_read(5'b00_011, R_ISR, v, d);
        check("R7 flag kept", 32'(d), 32'h0010);
        do_write(5'b11_000, R_CFG, 16'hC000);
        cyc(1);
        check("R7 foreign write ignored", 32'(blk_bypass), 0);
    endtask

    task automatic t_cfg;
        logic v; logic [15:0] d;
        do_write(5'b00_010, R_CFG, 16'hFFFF);
        do_write(5'b00_110, R_CFG, 16'h4000);
        check("R9 blk", 32'(blk_bypass), 32'h44);
        check("R9 scr", 32'(scr_bypass), 32'h04);
        do_read(5'b00_010, R_CFG, v, d);
        check("R8 readback p2", 32'(d), 32'hC000);
        do_read(5'b00_110, R_CFG, v, d);
        check("R8 readback p6", 32'(d), 32'h4000);
        pin_blk_bypass = 1'b1;
        cyc(1);
        check("R9 blk pin", 32'(blk_bypass), 32'hFF);
        check("R9 scr unaffected", 32'(scr_bypass), 32'h04);
        pin_blk_bypass = 1'b0; pin_scr_bypass = 1'b1;
        cyc(1);
        check("R9 scr pin", 32'(scr_bypass), 32'hFF);
        check("R9 blk back", 32'(blk_bypass), 32'h44);
        pin_scr_bypass = 1'b0;
    endtask

    task automatic t_strap;
        logic v; logic [15:0] d;
        strap = 2'b10;
        link_up[7] = ~link_up[7];
        cyc(3);
        do_read(5'b00_111, R_ISR, v, d);
        check("R10 old group ignored", 32'(v), 0);
        do_read(5'b10_111, R_ISR, v, d);
        check("R10 new group valid", 32'(v), 1);
        check("R10 new group data", 32'(d), 32'h0010);
        check("R10 irq released", 32'(irq_n), 1);
        strap = 2'b00;
    endtask

    initial begin
        cyc(3);
        t_reset;
        rst_n = 1'b1;
        cyc(2);
        t_reset;
        t_single;
        t_fall;
        t_sweep;
        t_reflag;
        t_set_wins;
        t_foreign;
        t_cfg;
        t_strap;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule